// File: doc/BRIEF.md
# Receive Frame Packer and Word Reader

This block is the receive buffer of a simple Ethernet MAC. Incoming frames arrive one byte per cycle on a byte stream marked with a last-byte flag. Each accepted frame is packed into a byte-wide circular store as one record. The record holds a fixed magic word and a header word carrying the stored length and an OK status. These are followed by the payload zero-padded to the minimum length, a CRC-32 over payload and padding, and zero fill up to the next 4-byte boundary.

The CPU side drains the store through a single 32-bit data register and can read how many complete records are pending. A reader state machine follows its position inside the current record. It steps through the magic word, the header and the body, and releases the record when the last body word is taken. A frame is taken only when reception is enabled and the store has room for a maximum-size record, so an accepted frame never overflows.

The packer FSM has seven states. PK_IDLE waits for a first byte and judges acceptance. PK_DATA stores payload bytes and PK_DROP discards a rejected frame up to its last byte. PK_PAD writes zero padding and PK_CRC writes the four CRC bytes. PK_FILL writes alignment zeros, and PK_HDR writes the magic and header bytes and then commits the record. Its transitions run IDLE→DATA or IDLE→DROP on a first byte, DATA→PAD or DATA→CRC on the last byte, PAD→CRC, CRC→FILL or CRC→HDR, FILL→HDR, HDR→IDLE and DROP→IDLE. The reader FSM has three states. RD_MAGIC moves to RD_HEAD on a pop. RD_HEAD moves to RD_BODY on a pop. RD_BODY returns to RD_MAGIC when the last body word is popped, and a flush also returns the reader to RD_MAGIC.

Top module: `rxq_frame_buffer`

## Requirements
- R1: After reset the pending count reads 0, the event flag (status register bit 0) is 0 and `rx_busy` is low.
- R2: A record starts with the magic word (default 0x0143414D), then a header word whose bits 15:0 hold the padded payload length plus 4 and whose bits 31:16 hold the OK code (default 0x0001). Every word a read returns has its lowest-addressed byte in bits 7:0.
- R3: A payload shorter than 60 bytes is stored followed by zero bytes up to 60 bytes in total.
- R4: After the padded payload, the record holds the complement of a CRC-32 as a little-endian word. The CRC uses reflected polynomial 0xEDB88320 and an all-ones start value, and covers payload and padding. Zero bytes then follow until the body length is a multiple of 4.
- R5: A frame is accepted only if `rx_enable` is high and at least 1532 bytes are free when its first byte arrives. Otherwise every byte up to and including the last is discarded and the pending count does not change.
- R6: Each committed record raises the pending count by one and sets the event flag. Writing a 1 in bit 0 to the status register (select 2) clears the flag, and writing 0 leaves it set.
- R7: Reads of the data register (select 0) return the magic word, then the header, then the header length rounded up to a multiple of 4 in body words. After the last body word the pending count falls by one and the next read starts a new record.
- R8: A data read while the pending count is 0 returns 0 and removes nothing.
- R9: Writing 0 to the count register (select 1) empties all committed records and resets the read position. Writing any other value has no effect.
- R10: Payload bytes beyond the 1520th are discarded. They are left out of storage, length and CRC.
- R11: When a record commits in the same cycle as the final word of another record is read, the pending count changes by +1 and −1 together and ends unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Reception enable, judged at each frame's first byte |
| in_valid | input | 1 | A frame byte is present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| rx_busy | output | 1 | Packer is finishing a record; no new frame may start |
| reg_rd | input | 1 | Register read strobe (a data read pops one word at the clock edge) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 data, 1 pending count, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register, valid in the strobe cycle |
| rx_event | output | 1 | Event flag, set when a record commits |

## Verification
The commit of a record by the packer and the release of another record by the reader can both land on the same clock edge. Both change the pending count. The bench leaves a frame pending with only its final word unread, then streams a 64-byte frame and times the final read so that it falls on the twelfth edge after the last input byte, which is the edge where that frame's header completes. The bench then expects the count still at 1, the event flag set and the next read to begin the new record with the magic word.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [2:0] {
        PK_IDLE,
        PK_DATA,
        PK_DROP,
        PK_PAD,
        PK_CRC,
        PK_FILL,
        PK_HDR
    } pk_state_e;

    typedef enum logic [1:0] {
        RD_MAGIC,
        RD_HEAD,
        RD_BODY
    } rd_state_e;

    localparam logic [1:0] SEL_DATA   = 2'd0;
    localparam logic [1:0] SEL_COUNT  = 2'd1;
    localparam logic [1:0] SEL_STATUS = 2'd2;

endpackage

// File: rtl/rxq_crc32_byte.sv
module rxq_crc32_byte #(
    parameter logic [31:0] POLY = 32'hEDB88320
) (
    input  logic [31:0] crc_in,
    input  logic [7:0]  data,
    output logic [31:0] crc_out
);
    always_comb begin
        logic [31:0] c;
        c = crc_in ^ {24'd0, data};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
        end
        crc_out = c;
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rword
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [AW-1:0] idx;
        assign idx = raddr + AW'(g);
        assign rword[8*g +: 8] = mem[idx];
    end
endmodule

// File: rtl/rxq_packer.sv
module rxq_packer
    import rxq_pkg::*;
#(
    parameter int          DEPTH   = 4096,
    parameter int          MIN_LEN = 60,
    parameter int          MAX_LEN = 1520,
    parameter int          ROOM    = 1532,
    parameter logic [31:0] MAGIC   = 32'h0143414D,
    parameter logic [15:0] OK_CODE = 16'h0001,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_enable,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic [AW:0]   rd_ptr,
    output logic [AW:0]   wr_base,
    output logic          busy,
    output logic          commit,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
    localparam logic [AW:0] ROOM_V  = (AW+1)'(ROOM);

    pk_state_e   state, nxt;
    logic [AW:0] wptr;
    logic [15:0] len, len_after;
    logic [31:0] crc, crc_next, crc_fin, hdr_word;
    logic [2:0]  idx;
    logic [7:0]  crc_byte;
    logic        crc_upd, take;
    logic [AW:0] used, free_b;
    logic        room_ok;

    assign used     = wr_base - rd_ptr;
    assign free_b   = DEPTH_V - used;
    assign room_ok  = free_b >= ROOM_V;
    assign crc_fin  = ~crc;
    assign hdr_word = {OK_CODE, len + 16'd4};
    assign len_after = len + {15'd0, take};

    rxq_crc32_byte u_crc (
        .crc_in (crc),
        .data   (crc_byte),
        .crc_out(crc_next)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PK_IDLE;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt       = state;
        mem_we    = 1'b0;
        mem_waddr = wptr[AW-1:0];
        mem_wdata = in_data;
        crc_byte  = in_data;
        crc_upd   = 1'b0;
        take      = 1'b0;
        commit    = 1'b0;
        unique case (state)
            PK_IDLE: begin
                if (in_valid) begin
                    if (rx_enable && room_ok) begin
                        take = 1'b1;
                        if (in_last) nxt = (len_after < 16'(MIN_LEN)) ? PK_PAD : PK_CRC;
                        else         nxt = PK_DATA;
                    end else if (!in_last) begin
                        nxt = PK_DROP;
                    end
                end
            end
            PK_DATA: begin
                if (in_valid) begin
                    take = len < 16'(MAX_LEN);
                    if (in_last) nxt = (len_after < 16'(MIN_LEN)) ? PK_PAD : PK_CRC;
                end
            end
            PK_DROP: begin
                if (in_valid && in_last) nxt = PK_IDLE;
            end
            PK_PAD: begin
                mem_we    = 1'b1;
                mem_wdata = 8'd0;
                crc_byte  = 8'd0;
                crc_upd   = 1'b1;
                if (len + 16'd1 >= 16'(MIN_LEN)) nxt = PK_CRC;
            end
            PK_CRC: begin
                mem_we    = 1'b1;
                mem_wdata = 8'(crc_fin >> {idx[1:0], 3'b000});
                if (idx[1:0] == 2'd3) nxt = (wptr[1:0] == 2'd3) ? PK_HDR : PK_FILL;
            end
            PK_FILL: begin
                mem_we    = 1'b1;
                mem_wdata = 8'd0;
                if (wptr[1:0] == 2'd3) nxt = PK_HDR;
            end
            PK_HDR: begin
                mem_we    = 1'b1;
                mem_waddr = wr_base[AW-1:0] + AW'(idx);
                mem_wdata = idx[2] ? 8'(hdr_word >> {idx[1:0], 3'b000})
                                   : 8'(MAGIC >> {idx[1:0], 3'b000});
                if (idx == 3'd7) begin
                    nxt    = PK_IDLE;
                    commit = 1'b1;
                end
            end
            default: nxt = PK_IDLE;
        endcase
        if (take) begin
            mem_we  = 1'b1;
            crc_upd = 1'b1;
        end
    end

    assign busy = (state == PK_PAD) || (state == PK_CRC) ||
                  (state == PK_FILL) || (state == PK_HDR);

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= (AW+1)'(8);
            wr_base <= '0;
            len     <= '0;
            crc     <= '1;
            idx     <= '0;
        end else begin
            if (mem_we && state != PK_HDR) wptr <= wptr + 1'b1;
            if (crc_upd) begin
                crc <= crc_next;
                len <= len + 16'd1;
            end
            if (state == PK_CRC) idx <= (idx[1:0] == 2'd3) ? 3'd0 : idx + 3'd1;
            if (state == PK_HDR) idx <= idx + 3'd1;
            if (commit) begin
                wr_base <= wptr;
                wptr    <= wptr + (AW+1)'(8);
                len     <= '0;
                crc     <= '1;
            end
        end
    end
endmodule

// File: rtl/rxq_reader.sv
module rxq_reader
    import rxq_pkg::*;
#(
    parameter int AW = 12,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    input  logic          commit,
    input  logic [AW:0]   wr_base,
    input  logic [31:0]   mem_word,
    output logic [AW:0]   rd_ptr,
    output logic [31:0]   reg_rdata,
    output logic [CW-1:0] frame_count,
    output logic          rx_event
);
    rd_state_e   rstate, rnxt;
    logic [15:0] remain;
    logic        pop, done, flush, ev_clr;

    assign flush  = reg_wr && reg_sel == SEL_COUNT && reg_wdata == 32'd0;
    assign ev_clr = reg_wr && reg_sel == SEL_STATUS && reg_wdata[0];
    assign pop    = reg_rd && reg_sel == SEL_DATA && frame_count != '0 && !flush;
    assign done   = pop && rstate == RD_BODY && remain == 16'd4;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) rstate <= RD_MAGIC;
        else        rstate <= rnxt;
    end

    // next state and read data
    always_comb begin
        rnxt = rstate;
        if (flush) begin
            rnxt = RD_MAGIC;
        end else if (pop) begin
            unique case (rstate)
                RD_MAGIC: rnxt = RD_HEAD;
                RD_HEAD:  rnxt = RD_BODY;
                RD_BODY:  if (done) rnxt = RD_MAGIC;
                default:  rnxt = RD_MAGIC;
            endcase
        end
        unique case (reg_sel)
            SEL_DATA:   reg_rdata = (frame_count != '0) ? mem_word : 32'd0;
            SEL_COUNT:  reg_rdata = 32'(frame_count);
            SEL_STATUS: reg_rdata = {31'd0, rx_event};
            default:    reg_rdata = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr      <= '0;
            remain      <= '0;
            frame_count <= '0;
            rx_event    <= 1'b0;
        end else begin
            if (flush) begin
                rd_ptr      <= wr_base;
                remain      <= '0;
                frame_count <= CW'(commit);
            end else begin
                frame_count <= frame_count + CW'(commit) - CW'(done);
                if (pop) begin
                    rd_ptr <= rd_ptr + (AW+1)'(4);
                    if (rstate == RD_HEAD) remain <= (mem_word[15:0] + 16'd3) & ~16'd3;
                    else if (rstate == RD_BODY) remain <= remain - 16'd4;
                end
            end
            if (commit)      rx_event <= 1'b1;
            else if (ev_clr) rx_event <= 1'b0;
        end
    end
endmodule

// File: rtl/rxq_frame_buffer.sv
module rxq_frame_buffer #(
    parameter int          DEPTH   = 4096,
    parameter int          MIN_LEN = 60,
    parameter int          MAX_LEN = 1520,
    parameter int          ROOM    = 1532,
    parameter int          CW      = 16,
    parameter logic [31:0] MAGIC   = 32'h0143414D,
    parameter logic [15:0] OK_CODE = 16'h0001,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_enable,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        rx_busy,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        rx_event
);
    logic [AW:0]   rd_ptr, wr_base;
    logic          commit, mem_we;
    logic [AW-1:0] mem_waddr;
    logic [7:0]    mem_wdata;
    logic [31:0]   mem_word;
    logic [CW-1:0] frame_count;

    rxq_packer #(
        .DEPTH(DEPTH), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN),
        .ROOM(ROOM), .MAGIC(MAGIC), .OK_CODE(OK_CODE)
    ) u_packer (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .rd_ptr(rd_ptr), .wr_base(wr_base), .busy(rx_busy), .commit(commit),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(rd_ptr[AW-1:0]), .rword(mem_word)
    );

    rxq_reader #(.AW(AW), .CW(CW)) u_reader (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .commit(commit),
        .wr_base(wr_base), .mem_word(mem_word), .rd_ptr(rd_ptr),
        .reg_rdata(reg_rdata), .frame_count(frame_count), .rx_event(rx_event)
    );
endmodule

// File: rtl/rxq_checks.sv
module rxq_checks #(
    parameter int AW = 12,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_enable,
    input logic          in_valid,
    input logic          rx_busy,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [1:0]    reg_sel,
    input logic [31:0]   reg_rdata,
    input logic          rx_event,
    input logic          commit,
    input logic [AW:0]   rd_ptr,
    input logic [CW-1:0] frame_count
);
    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_count > $past(frame_count)) |-> (frame_count == $past(frame_count) + 1'b1));

    // R6
    event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> rx_event);

    // R8
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == 2'd0 && frame_count == '0) |-> (reg_rdata == 32'd0));

    // R8
    empty_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_sel == 2'd0 && frame_count == '0) |=> $stable(rd_ptr));

    // R7
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_sel == 2'd0 && frame_count != '0)
        |=> (rd_ptr == $past(rd_ptr) + (AW+1)'(4)));

    // R5
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && in_valid && !rx_busy) |=> !commit);
endmodule

bind rxq_frame_buffer rxq_checks #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .in_valid(in_valid),
    .rx_busy(rx_busy), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_rdata(reg_rdata), .rx_event(rx_event), .commit(commit),
    .rd_ptr(rd_ptr), .frame_count(frame_count)
);

// File: tb/tb_rxq_frame_buffer.sv
module tb_rxq_frame_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        in_last = 1'b0;
    logic        rx_busy;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        rx_event;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];

    localparam logic [31:0] MAGIC_W = 32'h0143414D;

    rxq_frame_buffer dut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .rx_busy(rx_busy), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_event(rx_event)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed + i * 7) & 255);
    endfunction

    // builds the expected word list of one record into exp_q
    task automatic build_exp(input int n, input int seed);
        logic [7:0] bq[$];
        logic [31:0] c;
        int s, p;
        s = (n > 1520) ? 1520 : n;
        p = (s < 60) ? 60 : s;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < p; i++) begin
            logic [7:0] b;
            b = (i < s) ? pat(seed, i) : 8'd0;
            bq.push_back(b);
            c = c ^ {24'd0, b};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        for (int k = 0; k < 4; k++) bq.push_back(c[8*k +: 8]);
        while (bq.size() % 4 != 0) bq.push_back(8'd0);
        exp_q.delete();
        exp_q.push_back(MAGIC_W);
        exp_q.push_back({16'h0001, 16'(p + 4)});
        for (int w = 0; w < bq.size() / 4; w++)
            exp_q.push_back({bq[4*w+3], bq[4*w+2], bq[4*w+1], bq[4*w]});
    endtask

    task automatic send_frame(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pat(seed, i);
            in_last  = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        while (rx_busy) @(negedge clk);
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1;
        reg_sel = sel;
        #1 d = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_sel = sel;
        reg_wdata = v;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic expect_count(input int exp, input string tag);
        logic [31:0] d;
        reg_read(2'd1, d);
        check(d == 32'(exp), tag, d, 32'(exp));
    endtask

    task automatic drain(input int n, input int seed, input string tag);
        logic [31:0] d;
        build_exp(n, seed);
        for (int w = 0; w < exp_q.size(); w++) begin
            reg_read(2'd0, d);
            check(d == exp_q[w], tag, d, exp_q[w]);
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        expect_count(0, "R1 count after reset");
        reg_read(2'd2, d);
        check(d == 32'd0, "R1 event after reset", d, 32'd0);
        check(rx_busy == 1'b0, "R1 busy after reset", 32'(rx_busy), 32'd0);
    endtask

    task automatic t_empty_then_short;
        logic [31:0] d;
        reg_read(2'd0, d);
        check(d == 32'd0, "R8 empty read value", d, 32'd0);
        send_frame(10, 3);
        expect_count(1, "R6 count after short frame");
        drain(10, 3, "R8 R2 R3 R4 short padded record");
        expect_count(0, "R7 count after drain");
    endtask

    task automatic t_lengths;
        send_frame(60, 11);
        send_frame(61, 40);
        expect_count(2, "R6 two records");
        drain(60, 11, "R2 R4 record 60");
        expect_count(1, "R7 one left");
        drain(61, 40, "R4 record 61 with fill");
        expect_count(0, "R7 none left");
    endtask

    task automatic t_event;
        logic [31:0] d;
        reg_read(2'd2, d);
        check(d == 32'd1, "R6 event set", d, 32'd1);
        reg_write(2'd2, 32'd0);
        reg_read(2'd2, d);
        check(d == 32'd1, "R6 event kept on write 0", d, 32'd1);
        reg_write(2'd2, 32'd1);
        reg_read(2'd2, d);
        check(d == 32'd0, "R6 event cleared", d, 32'd0);
    endtask

    task automatic t_disabled;
        logic [31:0] d;
        rx_enable = 1'b0;
        send_frame(30, 5);
        expect_count(0, "R5 disabled frame rejected");
        reg_read(2'd2, d);
        check(d == 32'd0, "R5 no event when rejected", d, 32'd0);
        rx_enable = 1'b1;
        send_frame(30, 9);
        drain(30, 9, "R5 frame after re-enable");
    endtask

    task automatic t_flush;
        logic [31:0] d;
        send_frame(20, 1);
        send_frame(20, 2);
        reg_write(2'd1, 32'd5);
        expect_count(2, "R9 nonzero write ignored");
        reg_write(2'd1, 32'd0);
        expect_count(0, "R9 flush clears count");
        reg_read(2'd0, d);
        check(d == 32'd0, "R9 data after flush", d, 32'd0);
        send_frame(25, 77);
        drain(25, 77, "R9 record after flush");
    endtask

    task automatic t_room;
        send_frame(1530, 21);
        send_frame(1520, 22);
        expect_count(2, "R5 two large records");
        send_frame(100, 23);
        expect_count(2, "R5 rejected without room");
        drain(1530, 21, "R10 truncated record");
        send_frame(100, 24);
        expect_count(2, "R5 accepted with room");
        drain(1520, 22, "R5 second large");
        drain(100, 24, "R5 after room freed");
    endtask

    task automatic t_overlap;
        logic [31:0] d;
        send_frame(64, 50);
        build_exp(64, 50);
        for (int w = 0; w < exp_q.size() - 1; w++) begin
            reg_read(2'd0, d);
            check(d == exp_q[w], "R11 leading words", d, exp_q[w]);
        end
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pat(51, i);
            in_last  = (i == 63);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (11) @(negedge clk);
        reg_rd  = 1'b1;
        reg_sel = 2'd0;
        #1 d = reg_rdata;
        check(d == exp_q[exp_q.size()-1], "R11 final word", d, exp_q[exp_q.size()-1]);
        @(posedge clk);
        #1 reg_rd = 1'b0;
        while (rx_busy) @(negedge clk);
        expect_count(1, "R11 count after same-cycle commit and release");
        reg_read(2'd2, d);
        check(d == 32'd1, "R11 event set", d, 32'd1);
        drain(64, 51, "R11 new record intact");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        rx_enable = 1'b1;
        t_empty_then_short;
        t_lengths;
        t_event;
        t_disabled;
        t_flush;
        t_room;
        reg_write(2'd2, 32'd1);
        t_overlap;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule